// File: doc/BRIEF.md
# Round-Robin Iterative Crossbar Match Scheduler

This block computes, once per cell time, which input of a 4x4 input-queued crossbar may send to which output. Each input keeps one queue per output and shows the scheduler a request bit for every output it holds a cell for. Every output has a grant arbiter and every input has an accept arbiter. Each arbiter is a round-robin priority encoder with its own pointer register.

A start pulse loads the request matrix and clears the previous match. The block then runs one request-grant-accept round per clock, for a configured number of rounds between 1 and N. Each round only pairs inputs and outputs that are still free, so matches already made are kept. Pointers move only when a grant made in the first round is accepted. Each moved pointer lands one place past the partner that was just served, which gives that partner the lowest priority next time. Under load this spreads the grant pointers apart, so the outputs tend to grant distinct inputs.

When the last round is over, the block raises a one-cycle done pulse. The match then stays on its outputs, as a valid bit and an output index per input, until the next start.

Top module: `islip_sched`

## Requirements
- R1: After reset, done_o is 0, every match_vld_o bit is 0, every match_port_o field is 0, and all grant and accept pointers are 0, so the first cell favours the lowest-numbered input and output.
- R2: req_i and iters_i are sampled on the clock edge where start_i is high and the block is idle. Bit req_i[i*N+o] means input i has a cell for output o. A start_i, or any change of req_i, while a cell time is running has no effect on that cell time's result or timing.
- R3: With K equal to iters_i clamped to 1..N (0 counts as 1, values above N count as N), done_o is high in the K-th cycle after the start edge.
- R4: In each round, every output grants the first requesting free input found from its grant pointer upward, wrapping modulo N.
- R5: In each round, every free input that received grants accepts the first granting output found from its accept pointer upward, wrapping modulo N.
- R6: A grant pointer changes only when its grant is accepted in the first round. It then becomes one past the accepted input, modulo N. An accept pointer changes only on a first-round accept, and becomes one past the accepted output, modulo N. Later rounds and idle cycles leave every pointer unchanged.
- R7: Rounds after the first consider only inputs and outputs left unmatched by earlier rounds. A match is never removed during a cell time. No output is matched to more than one input, and each match is a requested pair.
- R8: Input i's result is match_vld_o[i] plus the 2-bit index match_port_o[i*2 +: 2]. An unmatched input reports index 0. The result holds from done_o until the next accepted start.
- R9: done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a cell time (taken only when idle) |
| iters_i | input | 3 | Number of rounds, clamped to 1..N |
| req_i | input | 16 | Request matrix, bit i*N+o = input i wants output o |
| done_o | output | 1 | One-cycle pulse when the match is final |
| match_vld_o | output | 4 | Per-input match valid |
| match_port_o | output | 8 | Per-input matched output index, 2 bits each |

## Verification
The bench builds the block with its default N = 4. This size is small enough to work out every grant, accept and pointer move by hand across a chained sequence of cell times. It is also large enough to show the pointers desynchronising until a full load matches completely in a single round. The 3-bit round count lets the bench reach the clamp for both 0 and values above N. The multi-round cases fill in the unmatched inputs and outputs one by one. The sparse request patterns leave an unaccepted grant pointer where it was.

// File: rtl/islip_pkg.sv
package islip_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sched_st_e;
endpackage

// File: rtl/islip_rr_arb.sv
// Programmable round-robin priority encoder: first set bit at or after ptr_i.
module islip_rr_arb #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  always_comb begin
    int c;
    idx_o = '0;
    vld_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      c = (int'(ptr_i) + k) % N;
      if (!vld_o && req_i[c]) begin
        vld_o = 1'b1;
        idx_o = IW'(c);
      end
    end
  end
endmodule

// File: rtl/islip_ptr.sv
// Pointer register: moves to one past the served index on update.
module islip_ptr #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [IW-1:0] sel_i,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (upd_i) ptr_q <= (int'(sel_i) == N - 1) ? '0 : sel_i + IW'(1);
  end

  assign ptr_o = ptr_q;

  assert_ptr_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) < N);
endmodule

// File: rtl/islip_sched.sv
module islip_sched
  import islip_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = $clog2(N),
  parameter int TW = $clog2(N + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [TW-1:0]   iters_i,
  input  logic [N*N-1:0]  req_i,
  output logic            done_o,
  output logic [N-1:0]    match_vld_o,
  output logic [N*IW-1:0] match_port_o
);
  sched_st_e      st_q;
  logic [N*N-1:0] req_q;
  logic [TW-1:0]  it_q, last_q, last_d;
  logic           done_q;
  logic [N-1:0]   mvld_q;
  logic [IW-1:0]  mport_q [N];

  logic [N-1:0]   out_free;
  logic [N-1:0]   g_req [N];
  logic [IW-1:0]  g_idx [N];
  logic [N-1:0]   g_vld;
  logic [N-1:0]   g_acc;
  logic [IW-1:0]  g_ptr [N];
  logic [N-1:0]   a_req [N];
  logic [IW-1:0]  a_idx [N];
  logic [N-1:0]   a_vld;
  logic [IW-1:0]  a_ptr [N];
  logic           first_rnd;

  assign first_rnd = (st_q == ST_RUN) && (it_q == '0);

  // Clamp requested rounds to 1..N, stored as last round index.
  always_comb begin
    if (iters_i == '0)           last_d = '0;
    else if (iters_i > TW'(N))   last_d = TW'(N - 1);
    else                         last_d = iters_i - TW'(1);
  end

  always_comb begin
    out_free = '1;
    for (int i = 0; i < N; i++)
      if (mvld_q[i]) out_free[mport_q[i]] = 1'b0;
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    for (genvar i = 0; i < N; i++) begin : g_col
      assign g_req[o][i] = req_q[i*N+o] & ~mvld_q[i] & out_free[o];
    end

    islip_rr_arb #(.N(N), .IW(IW)) u_garb (
      .req_i (g_req[o]),
      .ptr_i (g_ptr[o]),
      .idx_o (g_idx[o]),
      .vld_o (g_vld[o])
    );

    assign g_acc[o] = g_vld[o] && a_vld[g_idx[o]] && (a_idx[g_idx[o]] == IW'(o));

    islip_ptr #(.N(N), .IW(IW)) u_gptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (first_rnd && g_acc[o]),
      .sel_i  (g_idx[o]),
      .ptr_o  (g_ptr[o])
    );

    assert_gptr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !first_rnd |=> $stable(g_ptr[o]));
  end

  for (genvar i = 0; i < N; i++) begin : g_in
    for (genvar o = 0; o < N; o++) begin : g_row
      assign a_req[i][o] = g_vld[o] && (g_idx[o] == IW'(i));
    end

    islip_rr_arb #(.N(N), .IW(IW)) u_aarb (
      .req_i (a_req[i]),
      .ptr_i (a_ptr[i]),
      .idx_o (a_idx[i]),
      .vld_o (a_vld[i])
    );

    islip_ptr #(.N(N), .IW(IW)) u_aptr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .upd_i  (first_rnd && a_vld[i]),
      .sel_i  (a_idx[i]),
      .ptr_o  (a_ptr[i])
    );

    assign match_port_o[i*IW +: IW] = mport_q[i];

    assert_match_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_RUN && mvld_q[i]) |=> (mvld_q[i] && $stable(mport_q[i])));

    assert_match_requested_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mvld_q[i] |-> req_q[i*N + int'(mport_q[i])]);

    for (genvar j = i + 1; j < N; j++) begin : g_pair
      assert_out_unique_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mvld_q[i] && mvld_q[j]) |-> (mport_q[i] != mport_q[j]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      req_q   <= '0;
      it_q    <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
      mvld_q  <= '0;
      for (int i = 0; i < N; i++) mport_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          req_q  <= req_i;
          it_q   <= '0;
          last_q <= last_d;
          mvld_q <= '0;
          for (int i = 0; i < N; i++) mport_q[i] <= '0;
          st_q   <= ST_RUN;
        end
        default: begin
          for (int i = 0; i < N; i++)
            if (a_vld[i]) begin
              mvld_q[i]  <= 1'b1;
              mport_q[i] <= a_idx[i];
            end
          it_q <= it_q + TW'(1);
          if (it_q == last_q) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign done_o      = done_q;
  assign match_vld_o = mvld_q;

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (st_q == ST_IDLE));
endmodule

// File: tb/sim_islip_sched.sv
`timescale 1ns/1ps
module sim_islip_sched;
  localparam int N  = 4;
  localparam int IW = 2;
  localparam int TW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [TW-1:0]   iters = '0;
  logic [N*N-1:0]  req = '0;
  logic            done;
  logic [N-1:0]    mvld;
  logic [N*IW-1:0] mport;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  islip_sched #(.N(N)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .iters_i      (iters),
    .req_i        (req),
    .done_o       (done),
    .match_vld_o  (mvld),
    .match_port_o (mport)
  );

  // {req, iters, expected valid, expected ports {p3,p2,p1,p0}}; chained from reset pointers.
  localparam logic [30:0] VEC [7] = '{
    {16'hFFFF, 3'd1, 4'b0001, 8'h00},
    {16'hFFFF, 3'd4, 4'b1111, 8'hE1},
    {16'hFFFF, 3'd1, 4'b0111, 8'h06},
    {16'hFFFF, 3'd1, 4'b1111, 8'h1B},
    {16'h0000, 3'd2, 4'b0000, 8'h00},
    {16'h5040, 3'd1, 4'b1000, 8'h80},
    {16'h5040, 3'd2, 4'b1010, 8'h08}
  };

  function automatic int clamp_rounds(input int k);
    if (k < 1) return 1;
    if (k > N) return N;
    return k;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cell(input logic [15:0] r, input logic [TW-1:0] it, output int lat);
    @(negedge clk);
    start = 1'b1; req = r; iters = it;
    @(negedge clk);
    start = 1'b0; req = '0;
    lat = 0;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    int lat;
    logic [3:0] hv;
    logic [7:0] hp;
    repeat (3) @(negedge clk);
    check("R1 done in reset", 32'(done), 32'd0);
    check("R1 valid in reset", 32'(mvld), 32'd0);
    check("R8 ports in reset", 32'(mport), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", 32'(done), 32'd0);

    // Table: R4 R5 R6 R7 grant/accept/pointer chain, R3 latency
    foreach (VEC[v]) begin
      run_cell(VEC[v][30:15], VEC[v][14:12], lat);
      check($sformatf("R3 latency vec%0d", v), 32'(lat), 32'(clamp_rounds(int'(VEC[v][14:12]))));
      check($sformatf("R4 R5 R7 valid vec%0d", v), 32'(mvld), 32'(VEC[v][11:8]));
      check($sformatf("R6 R8 ports vec%0d", v), 32'(mport), 32'(VEC[v][7:0]));
      @(negedge clk);
      check($sformatf("R9 pulse vec%0d", v), 32'(done), 32'd0);
    end

    // R3: zero rounds counts as one; desynchronised pointers give a full match
    run_cell(16'hFFFF, 3'd0, lat);
    check("R3 clamp zero latency", 32'(lat), 32'd1);
    check("R6 full match valid", 32'(mvld), 32'hF);
    check("R6 full match ports", 32'(mport), 32'h6C);

    // R2 R3: over-range rounds clamp to N; start and req changes while busy ignored
    @(negedge clk);
    start = 1'b1; req = 16'h0001; iters = 3'd7;
    @(negedge clk);
    start = 1'b1; req = 16'hFFFF; iters = 3'd1;
    lat = 0;
    @(negedge clk);
    lat++;
    start = 1'b0; req = 16'hFFFF;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    check("R3 R2 clamp high latency", 32'(lat), 32'd4);
    check("R2 busy start ignored valid", 32'(mvld), 32'h1);
    check("R2 busy start ignored ports", 32'(mport), 32'h0);

    // R8: result held after done
    hv = mvld; hp = mport;
    repeat (3) @(negedge clk);
    check("R8 hold valid", 32'(mvld), 32'(hv));
    check("R8 hold ports", 32'(mport), 32'(hp));
    check("R9 no repeat done", 32'(done), 32'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule